// File: doc/BRIEF.md
# Clock Output Stop Sequencer

This block takes a set of free-running clocks and the request that powers them down. It gates the clock outputs low in a fixed order, with no glitches, before the oscillator and PLL of a clock generator are switched off. The request is an active-low, asynchronous level. One fast system clock samples the request and every clock input. The block uses each clock's sampled copy, and a one-cycle delayed copy of it, to find that clock's falling edges. Every output gate opens or closes only in a cycle where its sampled clock is low. An output is the sampled clock ANDed with its gate, so no stop or restart can produce a short high pulse.

A request only counts once it has been seen low at two consecutive rising edges of the CPU complement clock. The PCI free-running output stops first. The three buffered 66 MHz outputs stop next, and then the remaining group: PCI, 3V66, USB/DOT 48 MHz and the reference clock. Each output stops on its own next falling edge. The CPU pair is not gated low. Its true leg is parked at a driven-high level and its complement leg has its output enable removed. When every output is stopped and the CPU pair is parked, the block raises a shutdown output for the oscillator and PLL. Releasing the request drops that output at once. The sequencer then waits a lock delay and reopens all gates together, each one only while its own clock is low.

The seven sequencer states are RUN, SYNC, STOP_PCIF, STOP_66, STOP_REST, SHUTDOWN and WAKE. The transitions are:
- RUN to SYNC when the synchronised request is low.
- SYNC back to RUN if the request goes high; SYNC to STOP_PCIF on the second complement-clock rising edge.
- STOP_PCIF to STOP_66 once the PCI free-running output has stopped.
- STOP_66 to STOP_REST once all buffered outputs have stopped.
- STOP_REST to SHUTDOWN once the remaining outputs have stopped and the CPU pair is parked.
- Any of the three stop states to WAKE on an abort.
- SHUTDOWN to WAKE on release.
- WAKE to RUN once every gate is open and the CPU pair is unparked.

Top module: `clk_stop_seq`

## Requirements
- R1: A low request moves RUN to SYNC. The sequence starts (SYNC to STOP_PCIF) only after the request is seen low at two consecutive rising edges of the sampled CPU complement clock. A request that returns high during SYNC sends the block back to RUN, and no output stops.
- R2: In STOP_PCIF the PCI free-running output is the first to stop. Its gate closes on its next sampled falling edge, and the state then moves to STOP_66.
- R3: Each buffered 66 MHz output stops on its own falling edge, and only after the PCI free-running output has stopped. The state moves to STOP_REST when all three have stopped.
- R4: Each of the remaining outputs (lane order PCI, 3V66, USB, REF) stops on its own falling edge, and only after all buffered outputs have stopped.
- R5: The CPU pair is parked in STOP_REST and SHUTDOWN. When parked, cpu_t_out is 1, cpu_c_out is 0 and cpu_c_oe is 0. Parking and unparking happen only while the sampled true clock is high.
- R6: pll_off is 1 only in SHUTDOWN. That state is entered only after every gated output has stopped and the CPU pair is parked.
- R7: No runt pulses. A gate changes only in a cycle where its sampled clock is 0, and an output is never high while its sampled input is low.
- R8: Power-up is asynchronous. pll_off falls as soon as pwrdn_req_n rises, with no clock edge needed.
- R9: WAKE waits LOCK_CYC system cycles. It then opens every gate while that lane's sampled clock is low, unparks the CPU pair, and returns to RUN once all lanes run. WAKE lasts at least LOCK_CYC+1 cycles.
- R10: A request that returns high in STOP_PCIF, STOP_66 or STOP_REST aborts the sequence. The next state is WAKE, and SHUTDOWN is not visited.
- R11: status encodes the states as RUN=0, SYNC=1, STOP_PCIF=2, STOP_66=3, STOP_REST=4, SHUTDOWN=5, WAKE=6. After reset the state is RUN, cpu_c_oe is 1 and pll_off is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_req_n | input | 1 | Asynchronous active-low power-down request |
| cpu_t_in | input | 1 | CPU true clock |
| cpu_c_in | input | 1 | CPU complement clock |
| pcif_in | input | 1 | PCI free-running clock |
| ck66_in | input | N66 | Buffered 66 MHz clocks |
| rest_in | input | NREST | Remaining clocks: PCI, 3V66, USB, REF (bit 0 first) |
| pcif_out | output | 1 | Gated PCI free-running clock |
| ck66_out | output | N66 | Gated buffered 66 MHz clocks |
| rest_out | output | NREST | Gated remaining clocks |
| cpu_t_out | output | 1 | CPU true leg, held high when parked |
| cpu_c_out | output | 1 | CPU complement leg data |
| cpu_c_oe | output | 1 | Output enable of the complement leg |
| pll_off | output | 1 | Oscillator and PLL shutdown |
| status | output | 3 | Sequencer state code |

## Verification
The gate and parking assertions assume that every clock input stays at each level for at least one system cycle. In other words, every input clock runs at less than half the system clock rate, so each edge is seen by the sampling registers. The bench drives all input clocks from a cycle counter on the falling system edge, with periods of 4 to 14 system cycles. The request is changed a few nanoseconds after the falling edge, so that the asynchronous release path can be observed directly and the sampling registers never see a change at a clock edge.

// File: rtl/csq_pkg.sv
package csq_pkg;
    typedef enum logic [2:0] {
        CSQ_RUN       = 3'd0,
        CSQ_SYNC      = 3'd1,
        CSQ_STOP_PCIF = 3'd2,
        CSQ_STOP_66   = 3'd3,
        CSQ_STOP_REST = 3'd4,
        CSQ_SHUTDOWN  = 3'd5,
        CSQ_WAKE      = 3'd6
    } csq_state_e;
endpackage

// File: rtl/csq_lane.sv
module csq_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_in,
    input  logic stop,
    input  logic go,
    output logic ck_out,
    output logic stopped
);
    logic ck_d;
    logic ck_p;
    logic en;
    logic fall;

    assign fall = ck_p & ~ck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_d <= 1'b0;
            ck_p <= 1'b0;
            en   <= 1'b1;
        end else begin
            ck_p <= ck_d;
            ck_d <= ck_in;
            if (stop && fall)
                en <= 1'b0;
            else if (go && !ck_d)
                en <= 1'b1;
        end
    end

    assign ck_out  = ck_d & en;
    assign stopped = ~en;

    // R7
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en != $past(en)) |-> !$past(ck_d));

    // R2
    stop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(ck_p));
endmodule

// File: rtl/csq_cpu_park.sv
module csq_cpu_park (
    input  logic clk,
    input  logic rst_n,
    input  logic t_in,
    input  logic c_in,
    input  logic park_req,
    input  logic unpark_req,
    output logic t_out,
    output logic c_out,
    output logic c_oe,
    output logic parked,
    output logic c_rise
);
    logic t_d;
    logic c_d;
    logic c_p;
    logic park;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_d  <= 1'b0;
            c_d  <= 1'b0;
            c_p  <= 1'b0;
            park <= 1'b0;
        end else begin
            t_d <= t_in;
            c_d <= c_in;
            c_p <= c_d;
            if (t_d) begin
                if (park_req)
                    park <= 1'b1;
                else if (unpark_req)
                    park <= 1'b0;
            end
        end
    end

    assign c_rise = c_d & ~c_p;
    assign t_out  = t_d | park;
    assign c_out  = c_d & ~park;
    assign c_oe   = ~park;
    assign parked = park;

    // R5
    park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park != $past(park)) |-> $past(t_d));
endmodule

// File: rtl/csq_fsm.sv
module csq_fsm
    import csq_pkg::*;
#(
    parameter int LOCK_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       c_rise,
    input  logic       pcif_stopped,
    input  logic       all66_stopped,
    input  logic       any66_stopped,
    input  logic       allrest_stopped,
    input  logic       anyrest_stopped,
    input  logic       parked,
    input  logic       all_running,
    output csq_state_e state,
    output logic       stop_pcif,
    output logic       stop_66,
    output logic       stop_rest,
    output logic       go
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    csq_state_e    state_nxt;
    logic          seen;
    logic [LW-1:0] lock_cnt;
    logic          lock_done;

    assign lock_done = (state == CSQ_WAKE) && (lock_cnt == LW'(LOCK_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= CSQ_RUN;
            seen     <= 1'b0;
            lock_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state != CSQ_SYNC)
                seen <= 1'b0;
            else if (c_rise)
                seen <= 1'b1;
            if (state != CSQ_WAKE)
                lock_cnt <= '0;
            else if (!lock_done)
                lock_cnt <= lock_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        stop_pcif = 1'b0;
        stop_66   = 1'b0;
        stop_rest = 1'b0;
        go        = 1'b0;
        unique case (state)
            CSQ_RUN: begin
                go = 1'b1;
                if (!req_s) state_nxt = CSQ_SYNC;
            end
            CSQ_SYNC: begin
                go = 1'b1;
                if (req_s)                state_nxt = CSQ_RUN;
                else if (c_rise && seen)  state_nxt = CSQ_STOP_PCIF;
            end
            CSQ_STOP_PCIF: begin
                stop_pcif = 1'b1;
                if (req_s)             state_nxt = CSQ_WAKE;
                else if (pcif_stopped) state_nxt = CSQ_STOP_66;
            end
            CSQ_STOP_66: begin
                stop_pcif = 1'b1;
                stop_66   = 1'b1;
                if (req_s)              state_nxt = CSQ_WAKE;
                else if (all66_stopped) state_nxt = CSQ_STOP_REST;
            end
            CSQ_STOP_REST: begin
                stop_pcif = 1'b1;
                stop_66   = 1'b1;
                stop_rest = 1'b1;
                if (req_s)                          state_nxt = CSQ_WAKE;
                else if (allrest_stopped && parked) state_nxt = CSQ_SHUTDOWN;
            end
            CSQ_SHUTDOWN: begin
                stop_pcif = 1'b1;
                stop_66   = 1'b1;
                stop_rest = 1'b1;
                if (req_s) state_nxt = CSQ_WAKE;
            end
            CSQ_WAKE: begin
                go = lock_done;
                if (lock_done && all_running) state_nxt = CSQ_RUN;
            end
            default: state_nxt = CSQ_RUN;
        endcase
    end

    // R6
    shutdown_all_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CSQ_SHUTDOWN) |-> (pcif_stopped && all66_stopped && allrest_stopped && parked));

    // R3
    order_66_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CSQ_WAKE && any66_stopped) |-> pcif_stopped);

    // R4
    order_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CSQ_WAKE && anyrest_stopped) |-> all66_stopped);

    // R10
    abort_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CSQ_STOP_PCIF || state == CSQ_STOP_66 || state == CSQ_STOP_REST) && req_s)
        |=> (state == CSQ_WAKE));

    // R1
    sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CSQ_SYNC && req_s) |=> (state == CSQ_RUN));
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
    import csq_pkg::*;
#(
    parameter int N66      = 3,
    parameter int NREST    = 4,
    parameter int LOCK_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrdn_req_n,
    input  logic             cpu_t_in,
    input  logic             cpu_c_in,
    input  logic             pcif_in,
    input  logic [N66-1:0]   ck66_in,
    input  logic [NREST-1:0] rest_in,
    output logic             pcif_out,
    output logic [N66-1:0]   ck66_out,
    output logic [NREST-1:0] rest_out,
    output logic             cpu_t_out,
    output logic             cpu_c_out,
    output logic             cpu_c_oe,
    output logic             pll_off,
    output logic [2:0]       status
);
    localparam int NL = 1 + N66 + NREST;

    logic          req_m, req_s;
    logic [NL-1:0] lane_in, lane_out, lane_stop, lane_off;
    logic          stop_pcif, stop_66, stop_rest, go;
    logic          parked, c_rise;
    csq_state_e    state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_m <= 1'b1;
            req_s <= 1'b1;
        end else begin
            req_m <= pwrdn_req_n;
            req_s <= req_m;
        end
    end

    assign lane_in = {rest_in, ck66_in, pcif_in};

    generate
        for (genvar i = 0; i < NL; i++) begin : g_lane
            if (i == 0) begin : g_pcif
                assign lane_stop[i] = stop_pcif;
            end else if (i <= N66) begin : g_b66
                assign lane_stop[i] = stop_66;
            end else begin : g_rest
                assign lane_stop[i] = stop_rest;
            end
            csq_lane u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .ck_in  (lane_in[i]),
                .stop   (lane_stop[i]),
                .go     (go),
                .ck_out (lane_out[i]),
                .stopped(lane_off[i])
            );
        end
    endgenerate

    csq_cpu_park u_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .t_in      (cpu_t_in),
        .c_in      (cpu_c_in),
        .park_req  (stop_rest),
        .unpark_req(go),
        .t_out     (cpu_t_out),
        .c_out     (cpu_c_out),
        .c_oe      (cpu_c_oe),
        .parked    (parked),
        .c_rise    (c_rise)
    );

    csq_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_s          (req_s),
        .c_rise         (c_rise),
        .pcif_stopped   (lane_off[0]),
        .all66_stopped  (&lane_off[N66:1]),
        .any66_stopped  (|lane_off[N66:1]),
        .allrest_stopped(&lane_off[NL-1:N66+1]),
        .anyrest_stopped(|lane_off[NL-1:N66+1]),
        .parked         (parked),
        .all_running    (~|lane_off && !parked),
        .state          (state),
        .stop_pcif      (stop_pcif),
        .stop_66        (stop_66),
        .stop_rest      (stop_rest),
        .go             (go)
    );

    assign pcif_out = lane_out[0];
    assign ck66_out = lane_out[N66:1];
    assign rest_out = lane_out[NL-1:N66+1];
    assign pll_off  = (state == CSQ_SHUTDOWN) && !pwrdn_req_n;
    assign status   = state;

    // R5
    cpu_park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_c_oe |-> (cpu_t_out && !cpu_c_out));

    // R7
    no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcif_out) |=> pcif_out);
endmodule

// File: tb/tb_clk_stop_seq.sv
module tb_clk_stop_seq;
    localparam int LOCK = 20;
    localparam int NL   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       cpu_t_in = 1'b0, cpu_c_in = 1'b1, pcif_in = 1'b0;
    logic [2:0] ck66_in = '0;
    logic [3:0] rest_in = '0;
    logic       pcif_out, cpu_t_out, cpu_c_out, cpu_c_oe, pll_off;
    logic [2:0] ck66_out, status;
    logic [3:0] rest_out;

    clk_stop_seq #(.N66(3), .NREST(4), .LOCK_CYC(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_req_n(req_n),
        .cpu_t_in(cpu_t_in), .cpu_c_in(cpu_c_in), .pcif_in(pcif_in),
        .ck66_in(ck66_in), .rest_in(rest_in),
        .pcif_out(pcif_out), .ck66_out(ck66_out), .rest_out(rest_out),
        .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out), .cpu_c_oe(cpu_c_oe),
        .pll_off(pll_off), .status(status)
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0, wake_cyc = 0, max_st = 0;
    bit done = 1'b0, saw_sd = 1'b0, sum_done = 1'b0;

    // reference model state
    int m_st = 0, m_lock = 0;
    bit m_seen, m_rq1 = 1'b1, m_rq2 = 1'b1, m_ct, m_cc, m_cp, m_park;
    bit m_cur[NL], m_prv[NL], m_en[NL];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        if (!sum_done) begin
            sum_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    function automatic bit lane_stop(int st, int i);
        if (i == 0) return st >= 2 && st <= 5;
        if (i <= 3) return st >= 3 && st <= 5;
        return st == 4 || st == 5;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_lock = 0; m_seen = 0; m_rq1 = 1; m_rq2 = 1;
            m_ct = 0; m_cc = 0; m_cp = 0; m_park = 0;
            for (int i = 0; i < NL; i++) begin m_cur[i] = 0; m_prv[i] = 0; m_en[i] = 1; end
        end else begin
            bit [NL-1:0] vin;
            bit ne[NL];
            bit go, ldone, np, crise, all_off66, all_offr, all_on;
            int nst;
            vin   = {rest_in, ck66_in, pcif_in};
            ldone = (m_st == 6) && (m_lock == LOCK);
            go    = (m_st == 0) || (m_st == 1) || ldone;
            for (int i = 0; i < NL; i++) begin
                if (lane_stop(m_st, i) && m_prv[i] && !m_cur[i]) ne[i] = 0;
                else if (go && !m_cur[i]) ne[i] = 1;
                else ne[i] = m_en[i];
            end
            np = m_park;
            if (m_ct) begin
                if (m_st == 4 || m_st == 5) np = 1;
                else if (go) np = 0;
            end
            crise = m_cc && !m_cp;
            all_off66 = !m_en[1] && !m_en[2] && !m_en[3];
            all_offr  = !m_en[4] && !m_en[5] && !m_en[6] && !m_en[7];
            all_on = !m_park;
            for (int i = 0; i < NL; i++) if (!m_en[i]) all_on = 0;
            nst = m_st;
            case (m_st)
                0: if (!m_rq2) nst = 1;
                1: if (m_rq2) nst = 0; else if (crise && m_seen) nst = 2;
                2: if (m_rq2) nst = 6; else if (!m_en[0]) nst = 3;
                3: if (m_rq2) nst = 6; else if (all_off66) nst = 4;
                4: if (m_rq2) nst = 6; else if (all_offr && m_park) nst = 5;
                5: if (m_rq2) nst = 6;
                default: if (ldone && all_on) nst = 0;
            endcase
            m_seen = (m_st == 1) && (m_seen || crise);
            if (m_st != 6) m_lock = 0; else if (!ldone) m_lock++;
            for (int i = 0; i < NL; i++) begin
                m_prv[i] = m_cur[i]; m_cur[i] = vin[i]; m_en[i] = ne[i];
            end
            m_cp = m_cc; m_cc = cpu_c_in; m_ct = cpu_t_in; m_park = np;
            m_rq2 = m_rq1; m_rq1 = req_n;
            m_st = nst;
        end
    end

    // per-cycle comparison, then drive clocks for the next cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [2:0] e66;
            bit [3:0] er;
            for (int i = 0; i < 3; i++) e66[i] = m_cur[i+1] & m_en[i+1];
            for (int i = 0; i < 4; i++) er[i] = m_cur[i+4] & m_en[i+4];
            chk(pcif_out == (m_cur[0] & m_en[0]), "R2 pcif_out", pcif_out, m_cur[0] & m_en[0]);
            chk(ck66_out == e66, "R3 ck66_out", ck66_out, e66);
            chk(rest_out == er, "R4 rest_out", rest_out, er);
            chk({cpu_t_out, cpu_c_out, cpu_c_oe} == {m_park | m_ct, m_cc & !m_park, !m_park},
                "R5 cpu pair", {cpu_t_out, cpu_c_out, cpu_c_oe}, {m_park | m_ct, m_cc & !m_park, !m_park});
            chk(pll_off == (m_st == 5 && !req_n), "R6 pll_off", pll_off, m_st == 5 && !req_n);
            chk(status == m_st[2:0], "R11 status", status, m_st);
            chk(({rest_out, ck66_out, pcif_out} & ~{rest_in, ck66_in, pcif_in}) == 0,
                "R7 output high with low input", {rest_out, ck66_out, pcif_out}, 0);
            if (status == 6) wake_cyc++;
            if (int'(status) > max_st) max_st = int'(status);
            if (status == 5) saw_sd = 1'b1;
        end
        cyc++;
        pcif_in  = (cyc % 8) < 4;
        for (int k = 0; k < 3; k++) ck66_in[k] = ((cyc + k) % 6) < 3;
        rest_in[0] = (cyc % 10) < 5;
        rest_in[1] = (cyc % 12) < 6;
        rest_in[2] = (cyc % 14) < 7;
        rest_in[3] = (cyc % 4) < 2;
        cpu_t_in = ((cyc + 1) % 4) < 2;
        cpu_c_in = !cpu_t_in;
    end

    task automatic tick;
        @(negedge clk);
        #2;
    endtask

    task automatic wait_st(input int s, input string tag);
        for (int k = 0; k < 3000 && m_st != s; k++) tick();
        chk(m_st == s, tag, m_st, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!sum_done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R11 reset state
        chk(status == 0, "R11 reset status", status, 0);
        chk(cpu_c_oe == 1, "R11 reset oe", cpu_c_oe, 1);
        chk(pll_off == 0, "R11 reset pll_off", pll_off, 0);
        repeat (10) tick();

        // full power-down and power-up
        req_n = 1'b0;
        wait_st(5, "R1 reach SHUTDOWN");
        repeat (10) tick();
        chk(pll_off == 1, "R6 pll_off in shutdown", pll_off, 1);
        chk({rest_out, ck66_out, pcif_out} == 0, "R4 all stopped", {rest_out, ck66_out, pcif_out}, 0);
        chk(cpu_t_out == 1 && cpu_c_oe == 0, "R5 cpu parked", {cpu_t_out, cpu_c_oe}, 2);
        wake_cyc = 0;
        req_n = 1'b1;
        #1;
        chk(pll_off == 0, "R8 async release", pll_off, 0);
        wait_st(6, "R9 enter WAKE");
        wait_st(0, "R9 back to RUN");
        chk(wake_cyc >= LOCK + 1, "R9 lock delay", wake_cyc, LOCK + 1);
        chk(cpu_c_oe == 1, "R5 unparked", cpu_c_oe, 1);
        repeat (10) tick();

        // short request: rejected in SYNC
        max_st = 0;
        req_n = 1'b0;
        repeat (3) tick();
        req_n = 1'b1;
        repeat (20) tick();
        chk(max_st <= 1, "R1 short request rejected", max_st, 1);

        // abort from each stop state
        for (int s = 2; s <= 4; s++) begin
            saw_sd = 1'b0;
            req_n = 1'b0;
            wait_st(s, "R10 reach stop state");
            req_n = 1'b1;
            wait_st(6, "R10 abort to WAKE");
            wait_st(0, "R10 return to RUN");
            chk(!saw_sd, "R10 no shutdown on abort", saw_sd, 0);
            repeat (7) tick();
        end

        // second full cycle with different phase
        repeat (3) tick();
        req_n = 1'b0;
        wait_st(2, "R2 stop pcif first");
        wait_st(3, "R3 stop 66 next");
        chk(pcif_out == 0, "R3 pcif already low", pcif_out, 0);
        wait_st(4, "R4 stop rest next");
        chk(ck66_out == 0, "R4 ck66 already low", ck66_out, 0);
        wait_st(5, "R6 shutdown");
        repeat (5) tick();
        req_n = 1'b1;
        #1;
        chk(pll_off == 0, "R8 async release again", pll_off, 0);
        wait_st(0, "R9 RUN again");
        repeat (5) tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule